// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one DMA channel that copies data from a source address to a destination address through a simple memory-mapped master port. It does not take its transfer settings from registers. A start trigger makes it read a four-word descriptor from memory at a given pointer. The descriptor sets the source, the destination, the beat count, the beat size, the addressing modes and what happens when the block ends. A block is then carried out one beat at a time, and each beat is a read followed by a write. If the descriptor holds a nonzero link, the channel fetches the linked descriptor and runs the next block in the same transaction. A link that points back to an earlier descriptor gives a circular buffer.

The channel asks an external arbiter for the bus before every access. It drops its request for at least one cycle after every beat, so the arbiter can hand the bus to another master between any two beats. Software or an event input can suspend the channel. A descriptor can also ask for a suspend once its block is complete. A resume continues from the point where the channel stopped.

The channel reports progress in three ways:
- pulses when a beat ends and when a block ends;
- an event output whose source is chosen per descriptor;
- three sticky flags (done, suspend, error), each with its own interrupt enable.

Top module: `dmac_channel`

## Requirements
- R1: Any of the three start inputs (software, peripheral, event) makes an idle channel fetch four 32-bit words from the descriptor pointer `first_desc`:
  - +0: control byte in bits 7:0 and beat count minus one in bits 31:16;
  - +4: source address;
  - +8: destination address;
  - +12: next-descriptor pointer.
- R2: Control bits 2:1 select the beat size: 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. An incrementing address advances by 1, 2 or 4 bytes per beat. Data on the bus is right-aligned and `bus_size` carries the same code.
- R3: A count field of N-1 moves exactly N beats. `beat_done` pulses once per beat and `block_done` pulses once per block.
- R4: Control bit 3 makes the source address increment, and control bit 4 does the same for the destination. When a bit is clear, that address stays fixed for the whole block.
- R5: After a block whose next pointer is nonzero, the channel fetches that descriptor and continues. After a block whose next pointer is zero, the channel sets the done flag (flag bit 0) and returns to idle with its request low.
- R6: `bus_req`, `bus_addr` and `bus_we` hold steady until `bus_gnt` is seen. An access completes on a clock edge where both `bus_req` and `bus_gnt` are high. `bus_req` is low in the cycle after each beat's write.
- R7: A pulse on `susp_sw` or `susp_evt` stops the channel before its next beat, sets the suspend flag (bit 1) and keeps the request low. A pulse on `resume_sw` or `resume_evt` continues the block, and no beat is lost or repeated.
- R8: When control bit 5 is set and the next pointer is nonzero, the channel suspends after that block, before it fetches the next descriptor. A resume then runs the linked descriptor.
- R9: Control bits 7:6 choose the source of `evt_out`:
  - bit 6 gives a pulse at each block end;
  - bit 7 gives a pulse at each beat end;
  - 00 gives no pulses.
- R10: Either of two conditions sets the error flag (bit 2) and returns the channel to idle, and no further write takes place:
  - an error response on any access;
  - a descriptor whose control bit 0 (valid) is clear or whose size code is 3.
- R11: Each flag stays set until its `flag_clr` bit is pulsed. `irq` is high while any flag is set together with its `int_en` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_sw | input | 1 | Software start pulse |
| trig_periph | input | 1 | Peripheral start pulse |
| trig_evt | input | 1 | Event start pulse |
| first_desc | input | ADDR_W | Address of the first descriptor |
| susp_sw | input | 1 | Software suspend pulse |
| susp_evt | input | 1 | Event suspend pulse |
| resume_sw | input | 1 | Software resume pulse |
| resume_evt | input | 1 | Event resume pulse |
| bus_req | output | 1 | Access request to the arbiter |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| bus_wdata | output | DATA_W | Right-aligned write data |
| bus_gnt | input | 1 | Grant; the access completes when it is high together with the request |
| bus_rdata | input | DATA_W | Right-aligned read data, valid at grant |
| bus_err | input | 1 | Error response, valid at grant |
| beat_done | output | 1 | One-cycle pulse per finished beat |
| block_done | output | 1 | One-cycle pulse per finished block |
| evt_out | output | 1 | Event pulse selected by control bits 7:6 |
| flag_done | output | 1 | Sticky transfer-complete flag |
| flag_susp | output | 1 | Sticky suspend flag |
| flag_err | output | 1 | Sticky error flag |
| int_en | input | 3 | Interrupt enables (bit 0 done, 1 suspend, 2 error) |
| flag_clr | input | 3 | Flag clear pulses, same bit order |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds the grant low while the first fetch is waiting. It then checks that the request and address stay put and that no beat advances. A design that sampled the grant wrongly would skip or duplicate accesses. Fixed-source byte copies and fixed-destination halfword copies are checked against untouched guard bytes. A wrong step size or a mask that ignores the size would overwrite those guards or copy the wrong lanes. A suspend in the middle of a block and a suspend after a descriptor are each followed by a resume. A channel that lost its place would drop or repeat beats, or it would write the linked block too early. Invalid descriptors and error responses must leave the destination unchanged. A design that let errors through would keep writing after the fault.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } beat_sz_e;

  // Control byte of a descriptor; bit order is decoded by the sequencer.
  typedef struct packed {
    logic [1:0] evt_sel;     // [7:6] bit6 block end, bit7 beat end
    logic       susp_after;  // [5]
    logic       dst_inc;     // [4]
    logic       src_inc;     // [3]
    beat_sz_e   size;        // [2:1]
    logic       valid;       // [0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_CHK, ST_RD, ST_WR, ST_LINK, ST_SUSP
  } seq_st_e;

  function automatic logic [2:0] step_bytes(beat_sz_e sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dmac_irq_flags.sv
module dmac_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end
  end

  assign irq = |(flags & en);

endmodule

// File: rtl/dmac_xfer_regs.sv
module dmac_xfer_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_desc,
  input  logic              ld_en,
  input  logic [1:0]        ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              step,
  input  logic              link,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [ADDR_W-1:0] desc_ptr,
  output logic              last_beat,
  output logic              next_zero
);

  localparam int CNT_LSB = 16;

  logic [ADDR_W-1:0] next_ptr;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] stride;
  logic              unused_bits;

  assign stride      = ADDR_W'(step_bytes(ctrl.size));
  assign last_beat   = (remain == '0);
  assign next_zero   = (next_ptr == '0);
  assign unused_bits = ^ld_data[CNT_LSB-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      src      <= '0;
      dst      <= '0;
      desc_ptr <= '0;
      next_ptr <= '0;
      remain   <= '0;
    end else begin
      if (start) desc_ptr <= first_desc;
      if (link)  desc_ptr <= next_ptr;
      if (ld_en) begin
        case (ld_idx)
          2'd0: begin
            ctrl   <= ctrl_t'(ld_data[CTRL_W-1:0]);
            remain <= ld_data[CNT_LSB +: CNT_W];
          end
          2'd1:    src      <= ld_data[ADDR_W-1:0];
          2'd2:    dst      <= ld_data[ADDR_W-1:0];
          default: next_ptr <= ld_data[ADDR_W-1:0];
        endcase
      end
      if (step) begin
        if (ctrl.src_inc) src <= src + stride;
        if (ctrl.dst_inc) dst <= dst + stride;
        if (!last_beat)   remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       susp_req,
  input  logic       resume,
  input  logic       bus_gnt,
  input  logic       bus_err,
  input  ctrl_t      ctrl,
  input  logic       last_beat,
  input  logic       next_zero,
  output logic       bus_req,
  output logic       bus_we,
  output logic       fetch_ph,
  output logic [1:0] widx,
  output logic       start,
  output logic       ld_en,
  output logic       step,
  output logic       link,
  output logic       rd_cap,
  output logic       set_done,
  output logic       set_susp,
  output logic       set_err,
  output logic       beat_ev,
  output logic       block_ev
);

  seq_st_e st, nxt, ret_st, ret_val;
  logic    susp_pend, ret_ld, widx_clr, widx_inc;
  logic    acc_ok, acc_bad;

  assign bus_req  = (st == ST_FETCH) || (st == ST_RD) || (st == ST_WR);
  assign bus_we   = (st == ST_WR);
  assign fetch_ph = (st == ST_FETCH);
  assign acc_ok   = bus_req && bus_gnt && !bus_err;
  assign acc_bad  = bus_req && bus_gnt && bus_err;

  always_comb begin
    nxt = st;      start = 1'b0;   ld_en = 1'b0;    step = 1'b0;
    link = 1'b0;   rd_cap = 1'b0;  set_done = 1'b0; set_susp = 1'b0;
    set_err = 1'b0; beat_ev = 1'b0; block_ev = 1'b0; ret_ld = 1'b0;
    ret_val = ST_CHK; widx_clr = 1'b0; widx_inc = 1'b0;
    case (st)
      ST_IDLE: if (go) begin
        start = 1'b1; widx_clr = 1'b1; nxt = ST_FETCH;
      end
      ST_FETCH: begin
        if (acc_bad) begin
          set_err = 1'b1; nxt = ST_IDLE;
        end else if (acc_ok) begin
          ld_en = 1'b1;
          if (widx == 2'd3) nxt = ST_DECODE;
          else              widx_inc = 1'b1;
        end
      end
      ST_DECODE: begin
        if (!ctrl.valid || ctrl.size == SZ_BAD) begin
          set_err = 1'b1; nxt = ST_IDLE;
        end else nxt = ST_CHK;
      end
      ST_CHK: begin
        if (susp_pend) begin
          set_susp = 1'b1; ret_ld = 1'b1; ret_val = ST_CHK; nxt = ST_SUSP;
        end else nxt = ST_RD;
      end
      ST_RD: begin
        if (acc_bad) begin
          set_err = 1'b1; nxt = ST_IDLE;
        end else if (acc_ok) begin
          rd_cap = 1'b1; nxt = ST_WR;
        end
      end
      ST_WR: begin
        if (acc_bad) begin
          set_err = 1'b1; nxt = ST_IDLE;
        end else if (acc_ok) begin
          step = 1'b1; beat_ev = 1'b1;
          if (!last_beat) nxt = ST_CHK;
          else begin
            block_ev = 1'b1;
            if (next_zero) begin
              set_done = 1'b1; nxt = ST_IDLE;
            end else begin
              link = 1'b1; widx_clr = 1'b1;
              if (ctrl.susp_after) begin
                set_susp = 1'b1; ret_ld = 1'b1; ret_val = ST_FETCH; nxt = ST_SUSP;
              end else nxt = ST_LINK;
            end
          end
        end
      end
      ST_LINK: nxt = ST_FETCH;
      ST_SUSP: if (resume) nxt = ret_st;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ret_st    <= ST_CHK;
      widx      <= 2'd0;
      susp_pend <= 1'b0;
    end else begin
      st <= nxt;
      if (ret_ld)        ret_st <= ret_val;
      if (widx_clr)      widx <= 2'd0;
      else if (widx_inc) widx <= widx + 2'd1;
      if (st == ST_IDLE || st == ST_SUSP) susp_pend <= 1'b0;
      else if (susp_req)                  susp_pend <= 1'b1;
    end
  end

  // R6: bus released in the cycle after every completed write
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && bus_gnt) |=> !bus_req);

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_sw,
  input  logic              trig_periph,
  input  logic              trig_evt,
  input  logic [ADDR_W-1:0] first_desc,
  input  logic              susp_sw,
  input  logic              susp_evt,
  input  logic              resume_sw,
  input  logic              resume_evt,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              beat_done,
  output logic              block_done,
  output logic              evt_out,
  output logic              flag_done,
  output logic              flag_susp,
  output logic              flag_err,
  input  logic [2:0]        int_en,
  input  logic [2:0]        flag_clr,
  output logic              irq
);

  localparam int NFLAG = 3;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] src, dst, desc_ptr;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        widx;
  logic [NFLAG-1:0]  flags;
  logic fetch_ph, start, ld_en, step, link, rd_cap;
  logic set_done, set_susp, set_err, beat_ev, block_ev, last_beat, next_zero;

  dmac_seq u_seq (
    .clk, .rst,
    .go       (trig_sw | trig_periph | trig_evt),
    .susp_req (susp_sw | susp_evt),
    .resume   (resume_sw | resume_evt),
    .bus_gnt, .bus_err, .ctrl, .last_beat, .next_zero,
    .bus_req, .bus_we, .fetch_ph, .widx, .start, .ld_en, .step, .link,
    .rd_cap, .set_done, .set_susp, .set_err, .beat_ev, .block_ev
  );

  dmac_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk, .rst, .start, .first_desc, .ld_en,
    .ld_idx (widx), .ld_data (bus_rdata), .step, .link,
    .ctrl, .src, .dst, .desc_ptr, .last_beat, .next_zero
  );

  dmac_irq_flags #(.N(NFLAG)) u_flags (
    .clk, .rst,
    .set   ({set_err, set_susp, set_done}),
    .clr   (flag_clr),
    .en    (int_en),
    .flags (flags),
    .irq   (irq)
  );

  assign flag_done = flags[0];
  assign flag_susp = flags[1];
  assign flag_err  = flags[2];

  assign bus_addr  = fetch_ph ? desc_ptr + ADDR_W'({widx, 2'b00})
                              : (bus_we ? dst : src);
  assign bus_size  = fetch_ph ? SZ_WORD : ctrl.size;
  assign bus_wdata = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      beat_done  <= 1'b0;
      block_done <= 1'b0;
      evt_out    <= 1'b0;
    end else begin
      if (rd_cap) data_q <= bus_rdata;
      beat_done  <= beat_ev;
      block_done <= block_ev;
      evt_out    <= (block_ev & ctrl.evt_sel[0]) | (beat_ev & ctrl.evt_sel[1]);
    end
  end

  // R6: a waiting request keeps its address and direction
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R10: the error flag rises only with the channel off the bus
  a_r10_err_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_err) |-> !bus_req);

  // R7: the suspend flag rises only with the channel off the bus
  a_r7_susp_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_susp) |-> !bus_req);

  // R5: completion coincides with the final block pulse and an idle bus
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_done) |-> (!bus_req && block_done));

endmodule

// File: tb/tb_dmac_channel.sv
module tb_dmac_channel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_sw = 0, trig_periph = 0, trig_evt = 0;
  logic [31:0] first_desc = '0;
  logic        susp_sw = 0, susp_evt = 0, resume_sw = 0, resume_evt = 0;
  logic        bus_req, bus_we, bus_gnt = 1'b1, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        beat_done, block_done, evt_out;
  logic        flag_done, flag_susp, flag_err, irq;
  logic [2:0]  int_en = '0, flag_clr = '0;

  logic [7:0]  mem [0:4095];
  logic        hw_en = 1'b0;
  logic [11:0] hw_a = '0;
  logic [7:0]  hw_d = '0;
  int n_chk = 0, n_bad = 0;
  int beats = 0, blocks = 0, evts = 0, viol = 0;
  logic wr_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_channel dut (
    .clk, .rst, .trig_sw, .trig_periph, .trig_evt, .first_desc,
    .susp_sw, .susp_evt, .resume_sw, .resume_evt,
    .bus_req, .bus_we, .bus_addr, .bus_size, .bus_wdata,
    .bus_gnt, .bus_rdata, .bus_err,
    .beat_done, .block_done, .evt_out,
    .flag_done, .flag_susp, .flag_err, .int_en, .flag_clr, .irq
  );

  // memory model: byte array, right-aligned data, error above 0xFFF
  wire [11:0] ma = bus_addr[11:0];
  assign bus_err = bus_req && (bus_addr >= 32'h1000);
  always_comb begin
    bus_rdata = {mem[12'(ma+3)], mem[12'(ma+2)], mem[12'(ma+1)], mem[ma]};
    if (bus_size == 2'd0)      bus_rdata[31:8]  = '0;
    else if (bus_size == 2'd1) bus_rdata[31:16] = '0;
  end

  always @(posedge clk) begin
    if (bus_req && bus_gnt && bus_we && !bus_err) begin
      mem[ma] <= bus_wdata[7:0];
      if (bus_size != 2'd0) mem[12'(ma+1)] <= bus_wdata[15:8];
      if (bus_size == 2'd2) begin
        mem[12'(ma+2)] <= bus_wdata[23:16];
        mem[12'(ma+3)] <= bus_wdata[31:24];
      end
    end else if (hw_en) mem[hw_a] <= hw_d;
    if (beat_done)  beats  <= beats + 1;
    if (block_done) blocks <= blocks + 1;
    if (evt_out)    evts   <= evts + 1;
    if (wr_prev && bus_req) viol <= viol + 1;
    wr_prev <= bus_req && bus_gnt && bus_we;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wb(logic [11:0] a, logic [7:0] d);
    @(negedge clk); hw_en = 1'b1; hw_a = a; hw_d = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic w32(logic [11:0] a, logic [31:0] v);
    for (int i = 0; i < 4; i++) wb(12'(a + i), v[8*i +: 8]);
  endtask

  task automatic put_desc(logic [11:0] a, logic [7:0] c, int n,
                          logic [31:0] s, logic [31:0] d, logic [31:0] nx);
    w32(a, {16'(n - 1), 8'h00, c});
    w32(12'(a + 4), s);
    w32(12'(a + 8), d);
    w32(12'(a + 12), nx);
  endtask

  task automatic fill(logic [11:0] a, int n, logic [7:0] seed, logic [7:0] inc);
    for (int i = 0; i < n; i++) wb(12'(a + i), 8'(seed + inc * i));
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: trig_sw = 1;  1: trig_periph = 1; 2: trig_evt = 1;
      3: susp_sw = 1;  4: resume_sw = 1;   default: resume_evt = 1;
    endcase
    @(negedge clk);
    {trig_sw, trig_periph, trig_evt, susp_sw, resume_sw, resume_evt} = '0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 3'b111;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  task automatic wait_end();
    int k = 0;
    while (!(flag_done || flag_err || flag_susp) && k < 3000) begin
      @(negedge clk); k++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R6", "req after reset", 32'(bus_req), 0);
    chk("R11", "flags after reset", {29'b0, flag_err, flag_susp, flag_done}, 0);
    chk("R11", "irq after reset", 32'(irq), 0);
    chk("R3", "beat pulse after reset", 32'(beat_done), 0);
  endtask

  // word copy, both incrementing, block event, software start
  task automatic t_word_copy();
    int b0 = beats, k0 = blocks, e0 = evts;
    clr_flags(); int_en = 3'b001;
    fill(12'h200, 16, 8'h11, 8'h07);
    fill(12'h400, 20, 8'hEE, 8'h00);
    put_desc(12'h100, 8'h5D, 4, 32'h200, 32'h400, 32'h0);
    first_desc = 32'h100;
    pulse(0); wait_end();
    for (int i = 0; i < 16; i++)
      chk("R1", "word copy byte", {24'b0, mem[12'h400 + i]}, {24'b0, mem[12'h200 + i]});
    chk("R2", "guard after word block", {24'b0, mem[12'h410]}, 32'hEE);
    chk("R3", "beats in 4-beat block", 32'(beats - b0), 4);
    chk("R3", "block pulses", 32'(blocks - k0), 1);
    chk("R9", "block-mode events", 32'(evts - e0), 1);
    chk("R5", "done flag", 32'(flag_done), 1);
    chk("R5", "request low at end", 32'(bus_req), 0);
    chk("R11", "irq with done enabled", 32'(irq), 1);
    clr_flags();
    chk("R11", "done cleared", 32'(flag_done), 0);
    chk("R11", "irq after clear", 32'(irq), 0);
    int_en = 3'b000;
  endtask

  // byte beats, fixed source, beat events, peripheral start
  task automatic t_byte_fixed_src();
    int e0 = evts;
    clr_flags();
    fill(12'h200, 4, 8'hA5, 8'h10);
    fill(12'h400, 8, 8'hEE, 8'h00);
    put_desc(12'h100, 8'h91, 3, 32'h200, 32'h400, 32'h0);
    pulse(1); wait_end();
    for (int i = 0; i < 3; i++)
      chk("R4", "fixed source byte", {24'b0, mem[12'h400 + i]}, 32'hA5);
    chk("R2", "byte step leaves next byte", {24'b0, mem[12'h403]}, 32'hEE);
    chk("R9", "beat-mode events", 32'(evts - e0), 3);
  endtask

  // halfword beats, fixed destination, no events, event start
  task automatic t_half_fixed_dst();
    int e0 = evts;
    clr_flags();
    fill(12'h200, 6, 8'h31, 8'h01);
    fill(12'h400, 4, 8'hEE, 8'h00);
    put_desc(12'h100, 8'h0B, 3, 32'h200, 32'h400, 32'h0);
    pulse(2); wait_end();
    chk("R4", "fixed dest low byte", {24'b0, mem[12'h400]}, 32'h35);
    chk("R4", "fixed dest high byte", {24'b0, mem[12'h401]}, 32'h36);
    chk("R2", "half beat leaves byte 2", {24'b0, mem[12'h402]}, 32'hEE);
    chk("R9", "no events when disabled", 32'(evts - e0), 0);
    chk("R5", "done after half block", 32'(flag_done), 1);
  endtask

  // two linked descriptors
  task automatic t_chain();
    int k0 = blocks, e0 = evts;
    clr_flags();
    fill(12'h200, 12, 8'h40, 8'h03);
    fill(12'h400, 8, 8'hEE, 8'h00);
    fill(12'h440, 8, 8'hEE, 8'h00);
    put_desc(12'h100, 8'h5D, 2, 32'h200, 32'h400, 32'h140);
    put_desc(12'h140, 8'h5D, 1, 32'h208, 32'h440, 32'h0);
    pulse(0); wait_end();
    for (int i = 0; i < 8; i++)
      chk("R5", "first link block", {24'b0, mem[12'h400 + i]}, {24'b0, mem[12'h200 + i]});
    for (int i = 0; i < 4; i++)
      chk("R5", "second link block", {24'b0, mem[12'h440 + i]}, {24'b0, mem[12'h208 + i]});
    chk("R5", "blocks in chain", 32'(blocks - k0), 2);
    chk("R9", "events in chain", 32'(evts - e0), 2);
  endtask

  // grant withheld at start
  task automatic t_grant_stall();
    int b0 = beats;
    clr_flags();
    fill(12'h200, 8, 8'h70, 8'h05);
    fill(12'h400, 8, 8'hEE, 8'h00);
    put_desc(12'h180, 8'h5D, 2, 32'h200, 32'h400, 32'h0);
    first_desc = 32'h180;
    @(negedge clk); bus_gnt = 1'b0;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R6", "request held without grant", 32'(bus_req), 1);
    chk("R6", "address held without grant", bus_addr, 32'h180);
    chk("R6", "no beat without grant", 32'(beats - b0), 0);
    bus_gnt = 1'b1;
    wait_end();
    chk("R6", "copy after stall", {mem[12'h407], mem[12'h400]}, {mem[12'h207], mem[12'h200]});
    chk("R6", "release after each write", 32'(viol), 0);
    first_desc = 32'h100;
  endtask

  task automatic t_invalid_desc();
    clr_flags();
    fill(12'h400, 4, 8'hEE, 8'h00);
    put_desc(12'h100, 8'h5C, 1, 32'h200, 32'h400, 32'h0);
    pulse(0); wait_end();
    chk("R10", "error on invalid descriptor", 32'(flag_err), 1);
    chk("R10", "no done on invalid", 32'(flag_done), 0);
    chk("R10", "no write on invalid", {24'b0, mem[12'h400]}, 32'hEE);
    chk("R10", "idle after invalid", 32'(bus_req), 0);
  endtask

  task automatic t_bus_error();
    int b0 = beats;
    clr_flags();
    put_desc(12'h100, 8'h5D, 2, 32'h1000, 32'h400, 32'h0);
    pulse(0); wait_end();
    chk("R10", "error on bus fault", 32'(flag_err), 1);
    chk("R10", "no beat after fault", 32'(beats - b0), 0);
    chk("R10", "dest untouched after fault", {24'b0, mem[12'h400]}, 32'hEE);
  endtask

  task automatic t_suspend_mid();
    int b0 = beats, b1, k;
    clr_flags();
    fill(12'h200, 32, 8'h02, 8'h09);
    fill(12'h400, 32, 8'hEE, 8'h00);
    put_desc(12'h100, 8'h5D, 8, 32'h200, 32'h400, 32'h0);
    pulse(0);
    k = 0;
    while ((beats - b0) < 2 && k < 500) begin @(negedge clk); k++; end
    pulse(3); wait_end();
    chk("R7", "suspend flag", 32'(flag_susp), 1);
    b1 = beats;
    repeat (20) @(negedge clk);
    chk("R7", "no beats while suspended", 32'(beats), 32'(b1));
    chk("R7", "request low while suspended", 32'(bus_req), 0);
    chk("R7", "not done while suspended", 32'(flag_done), 0);
    clr_flags();
    pulse(4); wait_end();
    chk("R7", "done after resume", 32'(flag_done), 1);
    chk("R7", "total beats across suspend", 32'(beats - b0), 8);
    for (int i = 0; i < 32; i++)
      chk("R7", "data across suspend", {24'b0, mem[12'h400 + i]}, {24'b0, mem[12'h200 + i]});
  endtask

  task automatic t_suspend_after();
    clr_flags();
    fill(12'h200, 8, 8'hC0, 8'h01);
    fill(12'h400, 4, 8'hEE, 8'h00);
    fill(12'h480, 4, 8'hEE, 8'h00);
    put_desc(12'h100, 8'h7D, 1, 32'h200, 32'h400, 32'h140);
    put_desc(12'h140, 8'h5D, 1, 32'h204, 32'h480, 32'h0);
    pulse(0); wait_end();
    chk("R8", "suspend after descriptor", 32'(flag_susp), 1);
    chk("R8", "first block written", {24'b0, mem[12'h403]}, 32'hC3);
    chk("R8", "second block waits", {24'b0, mem[12'h480]}, 32'hEE);
    chk("R8", "not done before resume", 32'(flag_done), 0);
    clr_flags();
    pulse(5); wait_end();
    chk("R8", "done after event resume", 32'(flag_done), 1);
    chk("R8", "second block after resume",
        {mem[12'h483], mem[12'h480]}, {8'hC7, 8'hC4});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word_copy();
    t_byte_fixed_src();
    t_half_fixed_dst();
    t_chain();
    t_grant_stall();
    t_invalid_desc();
    t_bus_error();
    t_suspend_mid();
    t_suspend_after();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule